// File: doc/BRIEF.md
# Interrupt Event Ring Writer

This block turns per-channel event reports from a multichannel serial controller into 32-bit records kept in a circular table. The table sits in a small on-chip RAM that the block owns. Each report arrives as a one-cycle strobe with a flag vector and a channel number. The writer builds one record from them and places it at its write pointer.

Every record has a valid bit and a wrap bit, and ownership passes between the writer and the host through them. The writer fills only records whose valid bit is clear, and it sets that bit. The host reads a record, then writes the valid bit back to zero. The end of the ring is not given by a size register. It is marked by the wrap bit that software places in the final record. Once the writer has filled that record, its pointer reloads the base index.

The block raises an interrupt request each time a record is deposited. When the record at the pointer is still owned by the host, the event is dropped and a sticky overflow flag is raised. Both flags are cleared through a write-one-to-clear acknowledge input.

Top module: `evring_writer`

## Requirements
- R1: An accepted event writes the record at the write pointer as follows: bit 0 = 1 (valid), bit 1 = the wrap bit already held in that record, the masked flags in bits 2 to 11, the channel number in bits 16 upward, and zero in every other bit.
- R2: Flag masking. Bits 4 (slip end), 5 (slip start), 6 (transmit underrun), 7 (transmit buffer done), 10 (non-idle seen) and 11 (idle detected) are always copied from `ev_flags`. Bits 2, 3 and 9 are copied only when `alt_mode` is 1 and are zero otherwise. Bit 8 and bits 12 to 15 are always zero.
- R3: After a record whose wrap bit is 0, the pointer moves to the next index. After a record whose wrap bit is 1, it reloads `base_idx`.
- R4: While `enable` is 0, the pointer follows `base_idx` and event strobes leave the table and `irq` unchanged.
- R5: An event whose target record already has bit 0 set is dropped. The record keeps its contents, the pointer does not move, and `ovf` becomes 1.
- R6: `irq` rises in the cycle after an accepted event and stays at 1 until `h_ack[0]` is pulsed. If an event is accepted in the same cycle as the acknowledge, `irq` stays at 1.
- R7: `ovf` stays at 1 until `h_ack[1]` is pulsed.
- R8: Host reads return the record one cycle after `h_rd`. A host write replaces the whole record.
- R9: After reset, `irq`, `ovf` and `h_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Writer enable; when low the pointer is held at the base |
| base_idx | input | AW | Index of the first record in the ring |
| alt_mode | input | 1 | Passes flag bits 2, 3 and 9 into records |
| ev_valid | input | 1 | Event strobe |
| ev_flags | input | 12 | Event flags, at the same positions as in the record |
| ev_chan | input | CHW | Channel number of the event |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_addr | input | AW | Host record index |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| h_ack | input | 2 | Write-one-to-clear: bit 0 clears irq, bit 1 clears ovf |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that, while `enable` is high, the host never writes the record under the write pointer in the same cycle as an event. They also assume that `base_idx` only changes while `enable` is low. The directed bench keeps to both rules. It rewrites the table and the base only with the writer disabled, and it releases a record only when that record is known to be full and waiting. With those inputs, overflow can only follow from a full ring, and pointer movement can only follow from an accepted event.

// File: rtl/evring_writer.sv
module evring_writer #(
  parameter int DEPTH = 16,
  parameter int CHW   = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] base_idx,
  input  logic          alt_mode,
  input  logic          ev_valid,
  input  logic [11:0]   ev_flags,
  input  logic [CHW-1:0] ev_chan,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic [1:0]    h_ack,
  output logic          irq,
  output logic          ovf
);
  localparam logic [11:0] BASE_MASK = 12'hCF0;
  localparam logic [11:0] ALT_MASK  = 12'h20C;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [31:0]   cur;
  logic [11:0]   kept;
  logic [31:0]   rec;
  logic          accept, drop;
  logic [AW-1:0] next_ptr;

  assign cur    = mem[wptr];
  assign accept = enable && ev_valid && !cur[0];
  assign drop   = enable && ev_valid &&  cur[0];
  assign kept   = ev_flags & (alt_mode ? (BASE_MASK | ALT_MASK) : BASE_MASK);
  assign next_ptr = cur[1] ? base_idx
                  : (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;

  always_comb begin
    rec = '0;
    rec[11:2] = kept[11:2];
    rec[16 +: CHW] = ev_chan;
    rec[1] = cur[1];
    rec[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (h_wr) mem[h_addr] <= h_wdata;
    if (accept) mem[wptr] <= rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      irq     <= 1'b0;
      ovf     <= 1'b0;
      h_rdata <= '0;
    end else begin
      if (!enable) wptr <= base_idx;
      else if (accept) wptr <= next_ptr;
      if (accept) irq <= 1'b1;
      else if (h_ack[0]) irq <= 1'b0;
      if (drop) ovf <= 1'b1;
      else if (h_ack[1]) ovf <= 1'b0;
      if (h_rd) h_rdata <= mem[h_addr];
    end
  end
endmodule

module evring_writer_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [AW-1:0] base_idx,
  input logic [AW-1:0] wptr,
  input logic          accept,
  input logic          drop,
  input logic [1:0]    h_ack,
  input logic          irq,
  input logic          ovf
);
  // R5
  overflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);
  // R5
  drop_hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop && enable |=> $stable(wptr));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !h_ack[1] |=> ovf);
  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> irq);
  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !h_ack[0] |=> irq);
  // R4
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> wptr == $past(base_idx));
  // R4
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !irq |=> !irq);
endmodule

bind evring_writer evring_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .base_idx(base_idx),
  .wptr(wptr), .accept(accept), .drop(drop), .h_ack(h_ack),
  .irq(irq), .ovf(ovf)
);

// File: tb/evring_writer_bench.sv
module evring_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int CHW = 5;

  logic clk = 0, rst_n = 0;
  logic enable = 0, alt_mode = 0, ev_valid = 0, h_rd = 0, h_wr = 0;
  logic [AW-1:0] base_idx = '0, h_addr = '0;
  logic [11:0] ev_flags = '0;
  logic [CHW-1:0] ev_chan = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic [1:0] h_ack = '0;
  logic irq, ovf;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evring_writer #(.DEPTH(DEPTH), .CHW(CHW)) u_evring_writer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_idx(base_idx),
    .alt_mode(alt_mode), .ev_valid(ev_valid), .ev_flags(ev_flags),
    .ev_chan(ev_chan), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack), .irq(irq), .ovf(ovf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [11:0] f, logic alt, int ch, logic wrap);
    logic [11:0] m;
    m = f & (alt ? 12'hEFC : 12'hCF0);
    return {8'h0, 3'b0, 5'(ch), 4'h0, m[11:2], wrap, 1'b1};
  endfunction

  task automatic host_write(int a, logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = AW'(a); h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic host_read(int a, output logic [31:0] d);
    @(negedge clk); h_rd = 1; h_addr = AW'(a);
    @(negedge clk); h_rd = 0; d = h_rdata;
  endtask

  task automatic post_event(logic [11:0] f, int ch, logic [1:0] ack = 2'b00);
    @(negedge clk); ev_valid = 1; ev_flags = f; ev_chan = CHW'(ch); h_ack = ack;
    @(negedge clk); ev_valid = 0; h_ack = 0;
  endtask

  task automatic ack(logic [1:0] a);
    @(negedge clk); h_ack = a;
    @(negedge clk); h_ack = 0;
  endtask

  task automatic init_table(int base);
    @(negedge clk); enable = 0; base_idx = AW'(base);
    for (int i = 0; i < DEPTH; i++) host_write(i, (i == DEPTH-1) ? 32'h2 : 32'h0);
    @(negedge clk); enable = 1;
  endtask

  task automatic t_reset();
    check("R9 irq", 32'(irq), 0);
    check("R9 ovf", 32'(ovf), 0);
    check("R9 rdata", h_rdata, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    init_table(0);
    alt_mode = 0; post_event(12'hFFF, 3);
    check("R6 irq set", 32'(irq), 1);
    host_read(0, d); check("R1 R2 record0 alt off", d, mk(12'hFFF, 0, 3, 0));
    alt_mode = 1; post_event(12'hFFF, 5);
    host_read(1, d); check("R2 record1 alt on", d, mk(12'hFFF, 1, 5, 0));
    alt_mode = 0; post_event(12'h3A5, 17);
    host_read(2, d); check("R1 R3 record2", d, mk(12'h3A5, 0, 17, 0));
    ack(2'b01); check("R6 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_fill_overflow();
    logic [31:0] d;
    for (int i = 3; i < DEPTH; i++) post_event(12'h0C0, i);
    host_read(15, d); check("R1 R3 last record keeps wrap", d, mk(12'h0C0, 0, 15, 1));
    check("R5 no ovf yet", 32'(ovf), 0);
    post_event(12'hC00, 9);
    check("R5 ovf set", 32'(ovf), 1);
    host_read(0, d); check("R5 record0 untouched", d, mk(12'hFFF, 0, 3, 0));
    ack(2'b00); check("R7 ovf sticky", 32'(ovf), 1);
    host_write(0, 32'h0);
    ack(2'b10); check("R7 ovf cleared", 32'(ovf), 0);
    post_event(12'hC00, 9);
    host_read(0, d); check("R3 wrapped to base", d, mk(12'hC00, 0, 9, 0));
    check("R5 no ovf after release", 32'(ovf), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    ack(2'b01);
    @(negedge clk); enable = 0;
    post_event(12'hFFF, 1);
    check("R4 irq untouched", 32'(irq), 0);
    host_read(0, d); check("R4 record0 untouched", d, mk(12'hC00, 0, 9, 0));
  endtask

  task automatic t_base_and_ack_race();
    logic [31:0] d;
    init_table(8);
    post_event(12'h0F0, 2);
    host_read(8, d); check("R3 starts at base", d, mk(12'h0F0, 0, 2, 0));
    host_read(0, d); check("R3 below base empty", d, 0);
    post_event(12'h040, 4, 2'b01);
    check("R6 set wins over ack", 32'(irq), 1);
    for (int i = 10; i < DEPTH; i++) post_event(12'h080, i);
    host_write(8, 32'h0);
    post_event(12'h800, 30);
    host_read(8, d); check("R3 reload nonzero base", d, mk(12'h800, 0, 30, 0));
    host_write(5, 32'hDEADBEEF);
    host_read(5, d); check("R8 host write whole record", d, 32'hDEADBEEF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_layout();
    t_fill_overflow();
    t_disabled();
    t_base_and_ack_race();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule